// File: doc/BRIEF.md
# Autonomous Power-Gating Sequencer

This block runs from the always-on supply and manages one switchable power domain without any help from software. When the unit in the domain reports idle and no work is waiting, the block counts the quiet cycles. After enough of them it turns the domain off in a fixed order: it stops the clock, puts the unit into reset and then opens the header switch. The count stops shut-off during pauses too short to repay the slow supply ramp on wake.

When a work request arrives while the domain is off, the block closes the switch at once. It then waits for the power-good indication while the unit stays in reset with its clock stopped. Next it releases reset and enables the clock, one step at a time. Only then does it raise ready to tell requesters the unit can take work. A watchdog on the power-good wait raises a sticky error flag if the supply does not come up within a programmable number of cycles.

Top module: `pso_ctrl`

## Requirements
- R1: While and after reset, with no work request, every output is low: switch enable 0, domain reset asserted (dom_rst_n_o = 0), clock enable 0, ready 0 and error 0. The domain stays off until a request arrives.
- R2: With the domain on, the shut-off sequence begins at the clock edge that samples the N-th consecutive quiet cycle, where N = idle_limit_i and a quiet cycle has idle_i = 1 and work_req_i = 0. ready_o falls right after that edge and stays high after edge N-1.
- R3: A sampled cycle with work_req_i = 1 or idle_i = 0 sets the quiet count back to zero, so N more consecutive quiet cycles are needed.
- R4: idle_limit_i = 0 disables automatic shut-off: the domain stays on however long it is quiet.
- R5: Shut-off takes three single-cycle steps. First the clock is disabled with reset released and the switch closed. Then reset is asserted. Then the switch opens. Whenever the clock is enabled, reset is released, and whenever the switch is open, reset is asserted.
- R6: In the off state, a sampled work request closes the switch at the next edge, with reset asserted and the clock disabled.
- R7: Reset stays asserted and the clock disabled until an edge samples pgood_i = 1. That edge releases reset, the next edge enables the clock and the edge after raises ready_o.
- R8: If pgood_i is still low at the L-th edge spent waiting for it, where L = pg_limit_i, pg_err_o goes high after that edge. It stays high until reset, and the wait goes on.
- R9: A work request that arrives during the shut-off steps does not abort them. The switch still opens, and the wake-up starts from the off state.
- R10: ready_o is high only while the switch is closed, reset is released and the clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset of the controller |
| idle_i | input | 1 | Unit reports it has nothing to do |
| work_req_i | input | 1 | Work waiting for the unit (level, held until ready) |
| idle_limit_i | input | 16 | Quiet cycles needed before shut-off; 0 disables |
| pg_limit_i | input | 10 | Cycles allowed for power-good before the error flag |
| pgood_i | input | 1 | Gated supply has reached its level |
| sw_en_o | output | 1 | Closes the header switch |
| dom_rst_n_o | output | 1 | Active-low reset to the gated unit |
| dom_clk_en_o | output | 1 | Clock enable for the gated unit |
| ready_o | output | 1 | Unit is powered and can accept work |
| pg_err_o | output | 1 | Sticky power-good timeout flag |

## Verification
The bench counts each idle run exactly. A threshold off by one cycle, or a count that a request or idle drop fails to clear, shows up as ready falling one edge early or late. It checks every output on each step of the shut-off and wake order, so a reset released before power-good or a clock enabled before reset release is caught at once. It also tests a zero threshold held for hundreds of cycles, a request that lands in the middle of shut-off, and a supply that never comes up. A wrong design would show up as a domain that switches off, a sequence that stalls, or an error flag that never rises or clears on its own.

// File: rtl/pso_pkg.sv
package pso_pkg;

    typedef enum logic [3:0] {
        ST_ON,
        ST_CLK_OFF,
        ST_RST_ON,
        ST_SW_OFF,
        ST_OFF,
        ST_SW_ON,
        ST_WAIT_PG,
        ST_RST_OFF,
        ST_CLK_ON
    } pso_state_e;

    typedef struct packed {
        logic sw_en;
        logic rst_n;
        logic clk_en;
        logic ready;
    } pso_ctl_t;

    // Control outputs that belong to each state.
    function automatic pso_ctl_t pso_decode(pso_state_e st);
        pso_ctl_t c;
        c = '0;
        case (st)
            ST_ON:      c = '{sw_en: 1'b1, rst_n: 1'b1, clk_en: 1'b1, ready: 1'b1};
            ST_CLK_OFF: c = '{sw_en: 1'b1, rst_n: 1'b1, clk_en: 1'b0, ready: 1'b0};
            ST_RST_ON:  c = '{sw_en: 1'b1, rst_n: 1'b0, clk_en: 1'b0, ready: 1'b0};
            ST_SW_ON:   c = '{sw_en: 1'b1, rst_n: 1'b0, clk_en: 1'b0, ready: 1'b0};
            ST_WAIT_PG: c = '{sw_en: 1'b1, rst_n: 1'b0, clk_en: 1'b0, ready: 1'b0};
            ST_RST_OFF: c = '{sw_en: 1'b1, rst_n: 1'b1, clk_en: 1'b0, ready: 1'b0};
            ST_CLK_ON:  c = '{sw_en: 1'b1, rst_n: 1'b1, clk_en: 1'b1, ready: 1'b0};
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pso_idle_timer.sv
module pso_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             quiet_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W:0] seen;

    always_comb begin
        tmr_d = tmr_q;
        seen  = {1'b0, tmr_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (!armed_i || !quiet_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != CNT_MAX) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        expire_o = armed_i && quiet_i && (limit_i != '0) && (seen >= {1'b0, limit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R3: a busy cycle leaves the count at zero
    assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !quiet_i) |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/pso_pg_watchdog.sv
module pso_pg_watchdog #(
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_i,
    input  logic             pgood_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             err_o
);

    localparam logic [TMO_W-1:0] TMO_MAX = {TMO_W{1'b1}};

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             err;
    } wdg_t;

    wdg_t wdg_d, wdg_q;
    logic [TMO_W:0] spent;

    always_comb begin
        wdg_d = wdg_q;
        spent = {1'b0, wdg_q.cnt} + {{TMO_W{1'b0}}, 1'b1};
        if (!wait_i) begin
            wdg_d.cnt = '0;
        end else if (wdg_q.cnt != TMO_MAX) begin
            wdg_d.cnt = wdg_q.cnt + 1'b1;
        end
        if (wait_i && !pgood_i && (spent >= {1'b0, limit_i})) begin
            wdg_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdg_q <= '0;
        else        wdg_q <= wdg_d;
    end

    assign err_o = wdg_q.err;

    // R8: once raised the flag holds until reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_q.err |=> wdg_q.err);

    // R8: the flag only rises while waiting for power-good
    assert_err_when_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_q.err) |-> $past(wait_i));

endmodule

// File: rtl/pso_seq.sv
module pso_seq
    import pso_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic       work_req_i,
    input  logic       pgood_i,
    output pso_state_e state_o,
    output pso_ctl_t   ctl_o
);

    typedef struct packed {
        pso_state_e state;
        pso_ctl_t   ctl;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_ON:      if (expire_i)   seq_d.state = ST_CLK_OFF;
            ST_CLK_OFF:                 seq_d.state = ST_RST_ON;
            ST_RST_ON:                  seq_d.state = ST_SW_OFF;
            ST_SW_OFF:                  seq_d.state = ST_OFF;
            ST_OFF:     if (work_req_i) seq_d.state = ST_SW_ON;
            ST_SW_ON:                   seq_d.state = ST_WAIT_PG;
            ST_WAIT_PG: if (pgood_i)    seq_d.state = ST_RST_OFF;
            ST_RST_OFF:                 seq_d.state = ST_CLK_ON;
            ST_CLK_ON:                  seq_d.state = ST_ON;
            default:                    seq_d.state = ST_OFF;
        endcase
        // Outputs are registered so the switch and reset lines never glitch.
        seq_d.ctl = pso_decode(seq_d.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_OFF;
            seq_q.ctl   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.state;
    assign ctl_o   = seq_q.ctl;

    // R6: a request in the off state closes the switch at the next edge
    assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_OFF && work_req_i) |=> (seq_q.ctl.sw_en && !seq_q.ctl.rst_n));

    // R7: the wait only ends on power-good
    assert_hold_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_WAIT_PG && !pgood_i) |=> (seq_q.state == ST_WAIT_PG));

    // R7: reset release follows a sampled power-good
    assert_rst_after_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.ctl.rst_n) |-> $past(pgood_i));

    // R9: shut-off steps never turn back
    assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RST_ON) |=> !seq_q.ctl.sw_en);

endmodule

// File: rtl/pso_ctrl.sv
module pso_ctrl
    import pso_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int TMO_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              work_req_i,
    input  logic [IDLE_W-1:0] idle_limit_i,
    input  logic [TMO_W-1:0]  pg_limit_i,
    input  logic              pgood_i,
    output logic              sw_en_o,
    output logic              dom_rst_n_o,
    output logic              dom_clk_en_o,
    output logic              ready_o,
    output logic              pg_err_o
);

    pso_state_e state;
    pso_ctl_t   ctl;
    logic       armed;
    logic       quiet;
    logic       expire;
    logic       waiting;

    assign armed   = (state == ST_ON);
    assign quiet   = idle_i && !work_req_i;
    assign waiting = (state == ST_WAIT_PG);

    pso_idle_timer #(.CNT_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .quiet_i  (quiet),
        .limit_i  (idle_limit_i),
        .expire_o (expire)
    );

    pso_pg_watchdog #(.TMO_W(TMO_W)) u_wdg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_i  (waiting),
        .pgood_i (pgood_i),
        .limit_i (pg_limit_i),
        .err_o   (pg_err_o)
    );

    pso_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .work_req_i (work_req_i),
        .pgood_i    (pgood_i),
        .state_o    (state),
        .ctl_o      (ctl)
    );

    assign sw_en_o      = ctl.sw_en;
    assign dom_rst_n_o  = ctl.rst_n;
    assign dom_clk_en_o = ctl.clk_en;
    assign ready_o      = ctl.ready;

    // R10: ready only with the domain fully up
    assert_ready_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (sw_en_o && dom_rst_n_o && dom_clk_en_o));

    // R5: a running clock implies released reset
    assert_clk_needs_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clk_en_o |-> dom_rst_n_o);

    // R5: an open switch implies asserted reset
    assert_off_in_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en_o |-> !dom_rst_n_o);

    // R4: a zero threshold keeps the domain up
    assert_limit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && idle_limit_i == '0) |=> ready_o);

    // R2: shut-off begins by stopping the clock with power still applied
    assert_clk_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> (sw_en_o && dom_rst_n_o && !dom_clk_en_o));

endmodule

// File: tb/tb_pso_ctrl.sv
module tb_pso_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_i = 1'b0;
    logic        work_req_i = 1'b0;
    logic [15:0] idle_limit_i = 16'd8;
    logic [9:0]  pg_limit_i = 10'd200;
    logic        pgood_i;
    logic        sw_en_o, dom_rst_n_o, dom_clk_en_o, ready_o, pg_err_o;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned pg_dly = 6;
    logic        pg_block = 1'b0;
    logic [31:0] pg_sh = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // Supply ramp model: power-good follows the switch after pg_dly edges.
    always @(posedge clk) pg_sh <= {pg_sh[30:0], sw_en_o};
    assign pgood_i = pg_sh[pg_dly-1] && !pg_block;

    pso_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_i       (idle_i),
        .work_req_i   (work_req_i),
        .idle_limit_i (idle_limit_i),
        .pg_limit_i   (pg_limit_i),
        .pgood_i      (pgood_i),
        .sw_en_o      (sw_en_o),
        .dom_rst_n_o  (dom_rst_n_o),
        .dom_clk_en_o (dom_clk_en_o),
        .ready_o      (ready_o),
        .pg_err_o     (pg_err_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ctl_word();
        return {sw_en_o, dom_rst_n_o, dom_clk_en_o, ready_o};
    endfunction

    task automatic expect_ctl(input int exp, input string req);
        check(ctl_word() == exp, req, ctl_word(), exp);
    endtask

    // Wake from off; expects ready exactly pg_dly+4 edges after the request edge.
    task automatic wake(input string req);
        int n;
        int rst_edge;
        int clk_edge;
        n = 0;
        rst_edge = 0;
        clk_edge = 0;
        idle_i = 1'b0;
        work_req_i = 1'b1;
        while (!ready_o && n < 80) begin
            step();
            n++;
            if (n == 1) expect_ctl(4'b1000, "R6");
            if (dom_rst_n_o && rst_edge == 0) rst_edge = n;
            if (dom_clk_en_o && clk_edge == 0) clk_edge = n;
        end
        check(rst_edge == int'(pg_dly) + 2, "R7", rst_edge, pg_dly + 2);
        check(clk_edge == int'(pg_dly) + 3, "R7", clk_edge, pg_dly + 3);
        check(n == int'(pg_dly) + 4, req, n, pg_dly + 4);
        work_req_i = 1'b0;
    endtask

    // Count quiet edges until ready falls; returns the count.
    task automatic quiet_until_off(input int max_n, output int n);
        n = 0;
        idle_i = 1'b1;
        work_req_i = 1'b0;
        while (ready_o && n < max_n) begin
            step();
            n++;
        end
    endtask

    task automatic settle_off();
        idle_i = 1'b0;
        work_req_i = 1'b0;
        repeat (40) step();
    endtask

    initial begin
        int n;
        repeat (3) step();
        // R1 reset state
        expect_ctl(0, "R1");
        check(pg_err_o == 1'b0, "R1", pg_err_o, 0);
        rst_n = 1'b1;
        repeat (6) step();
        expect_ctl(0, "R1");

        // R7 wake latency and ordering
        wake("R7");

        // R2 and R5: exact threshold and shut-off steps
        idle_limit_i = 16'd10;
        idle_i = 1'b1;
        repeat (9) step();
        check(ready_o == 1'b1, "R2", ready_o, 1);
        step();
        expect_ctl(4'b1100, "R2");
        step();
        expect_ctl(4'b1000, "R5");
        step();
        expect_ctl(4'b0000, "R5");
        step();
        expect_ctl(4'b0000, "R5");
        settle_off();

        // R3: a request restarts the count
        wake("R7");
        idle_i = 1'b1;
        repeat (6) step();
        work_req_i = 1'b1;
        step();
        work_req_i = 1'b0;
        repeat (9) step();
        check(ready_o == 1'b1, "R3", ready_o, 1);
        step();
        check(ready_o == 1'b0, "R3", ready_o, 0);
        settle_off();

        // R3: idle dropping restarts the count
        wake("R7");
        idle_i = 1'b1;
        repeat (8) step();
        idle_i = 1'b0;
        step();
        idle_i = 1'b1;
        repeat (9) step();
        check(ready_o == 1'b1, "R3", ready_o, 1);
        step();
        check(ready_o == 1'b0, "R3", ready_o, 0);
        settle_off();

        // R4: zero threshold
        wake("R7");
        idle_limit_i = 16'd0;
        idle_i = 1'b1;
        repeat (300) step();
        expect_ctl(4'b1111, "R4");
        work_req_i = 1'b1;
        step();
        work_req_i = 1'b0;
        idle_limit_i = 16'd3;
        repeat (2) step();
        check(ready_o == 1'b1, "R4", ready_o, 1);
        step();
        check(ready_o == 1'b0, "R4", ready_o, 0);

        // R9: request during shut-off does not abort it
        work_req_i = 1'b1;
        idle_i = 1'b0;
        step();
        expect_ctl(4'b1000, "R9");
        step();
        expect_ctl(4'b0000, "R9");
        n = 0;
        while (!ready_o && n < 80) begin
            step();
            n++;
        end
        check(ready_o == 1'b1, "R9", ready_o, 1);
        work_req_i = 1'b0;
        quiet_until_off(10, n);
        check(n == 3, "R2", n, 3);
        settle_off();

        // R8: power-good timeout
        pg_block = 1'b1;
        pg_limit_i = 10'd5;
        work_req_i = 1'b1;
        repeat (6) step();
        check(pg_err_o == 1'b0, "R8", pg_err_o, 0);
        step();
        check(pg_err_o == 1'b1, "R8", pg_err_o, 1);
        repeat (20) step();
        expect_ctl(4'b1000, "R8");
        pg_block = 1'b0;
        n = 0;
        while (!ready_o && n < 80) begin
            step();
            n++;
        end
        check(ready_o == 1'b1, "R8", ready_o, 1);
        check(pg_err_o == 1'b1, "R8", pg_err_o, 1);
        work_req_i = 1'b0;

        // R1: reset clears the flag and turns the domain off
        rst_n = 1'b0;
        step();
        expect_ctl(0, "R1");
        check(pg_err_o == 1'b0, "R1", pg_err_o, 0);
        rst_n = 1'b1;
        pg_limit_i = 10'd1000;
        settle_off();

        // Random: quiet-run model against ready, random ramp delay.
        begin
            int unsigned seed_v;
            seed_v = $urandom(1234);
            for (int it = 0; it < 25; it++) begin
                int lim;
                int run;
                bit off_seen;
                pg_dly = 1 + ($urandom % 20);
                lim = 1 + int'($urandom % 12);
                idle_limit_i = 16'(lim);
                wake("R7");
                run = 0;
                off_seen = 1'b0;
                for (int c = 0; c < 400 && !off_seen; c++) begin
                    int r;
                    r = int'($urandom % 10);
                    idle_i = (r != 0);
                    work_req_i = (r == 1);
                    run = (idle_i && !work_req_i) ? run + 1 : 0;
                    step();
                    if (run >= lim) begin
                        check(ready_o == 1'b0, "R2", ready_o, 0);
                        off_seen = 1'b1;
                    end else begin
                        check(ready_o == 1'b1, "R3", ready_o, 1);
                    end
                end
                work_req_i = 1'b0;
                idle_i = 1'b0;
                repeat (3) step();
                check(sw_en_o == 1'b0, "R5", sw_en_o, 0);
                check(pg_err_o == 1'b0, "R8", pg_err_o, 0);
                settle_off();
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule